// File: doc/BRIEF.md
# Interleaved Reference Window Memory

This block holds the reference search window used by a motion search engine. The window is 128 pixels wide and 128 rows tall, with 8-bit pixels packed eight to a 64-bit word, so a row is 16 words. Words with an even column index sit in one pair of 32-bit banks and words with an odd column index sit in a second pair. Any read therefore fetches two neighbouring words in the same cycle. The block then returns the eight consecutive pixels that start at any pixel position, aligned or not.

Every bank has one port for reads and one for writes. An external loader can refill the window one 64-bit word per cycle while the search keeps reading, and no read ever stalls. Read columns are relative to a window base. The base moves forward by 16 pixels, modulo 128, each time a macroblock completes. With it, the search addresses a fixed 112-pixel span while the spare 16-pixel column is refilled behind it.

Top module: `ref_window_mem`

## Requirements
- R1: A read whose start pixel is a multiple of 8 returns the eight pixels of that one word on `rd_data` on the clock edge after `rd_en` is sampled, with `rd_valid` high in that same cycle.
- R2: The returned word puts pixel k of the run (k = 0..7, counted left to right from the start pixel) in bits 8k+7..8k. An unaligned start joins the tail of the first word with the head of the following word.
- R3: When the start pixel lies in an odd-indexed word, the run continues into the next even-indexed word of the same row, which is held in the other bank pair.
- R4: A run that passes the last word of a row (word 15) continues at word 0 of the same row, because physical columns wrap modulo 128 pixels.
- R5: The physical read column is (`rd_x` + `win_base`) mod 128. `win_base` is 0 after reset and advances by 16 modulo 128 on each cycle that `adv_en` is sampled high. Otherwise it holds.
- R6: A write of word `wr_word` in row `wr_row` replaces all eight of that word's pixels. A read of a different word issued in the same cycle is unaffected, and later reads return the new data.
- R7: A read issued in the same cycle as a write to the same word returns the data held before the write.
- R8: `rd_valid` is low in every cycle that follows a cycle with `rd_en` low. `rd_data` then keeps its previous value.
- R9: While `rst_n` is low and right after its release, `rd_valid` is 0 and `win_base` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | 1 | Macroblock done: advance the window base by 16 pixels |
| win_base | output | 7 | Current window base, in pixels |
| wr_en | input | 1 | Write one 64-bit word |
| wr_row | input | 7 | Row of the word being written |
| wr_word | input | 4 | Physical word column (0..15) within the row |
| wr_data | input | 64 | Eight pixels, leftmost pixel in bits 7..0 |
| rd_en | input | 1 | Read request |
| rd_row | input | 7 | Row to read |
| rd_x | input | 7 | Start pixel relative to the window base |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| rd_data | output | 64 | Eight pixels from the start pixel, first pixel in bits 7..0 |

## Verification
Every read result is due exactly one clock edge after the request: the banks register their outputs, and the pixel select after them is combinational. The bench drives a request on a falling edge and lowers `rd_en` on the next falling edge. It compares `rd_data` and `rd_valid` at that falling edge, so the only rising edge in between is the one that captures the bank outputs. A write is seen by a read issued in a later cycle. A base advance shows on `win_base` after the edge that samples `adv_en`, so the bench checks the base and reads relative to it only after that edge.

// File: rtl/ref_window_mem.sv
module ref_window_mem #(
  parameter int PIX_BITS  = 8,
  parameter int WORD_PIX  = 8,
  parameter int ROW_WORDS = 16,
  parameter int ROWS      = 128,
  parameter int STEP_PIX  = 16,
  localparam int WORD_W = PIX_BITS * WORD_PIX,
  localparam int HALF_W = WORD_W / 2,
  localparam int XW     = $clog2(ROW_WORDS * WORD_PIX),
  localparam int YW     = $clog2(ROWS),
  localparam int CW     = $clog2(ROW_WORDS),
  localparam int BW     = $clog2(WORD_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  output logic [XW-1:0]     win_base,
  input  logic              wr_en,
  input  logic [YW-1:0]     wr_row,
  input  logic [CW-1:0]     wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [YW-1:0]     rd_row,
  input  logic [XW-1:0]     rd_x,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = ROWS * ROW_WORDS / 2;
  localparam int AW    = YW + CW - 1;

  logic [XW-1:0] phys_x;
  logic [CW-1:0] word;
  logic [CW-2:0] pair_col;
  logic [AW-1:0] even_addr, odd_addr, wr_addr;
  logic [HALF_W-1:0] bank_q [4];
  logic          first_odd_q;
  logic [BW-1:0] ofs_q;
  logic [2*WORD_W-1:0] joined;

  assign phys_x    = rd_x + win_base;
  assign word      = phys_x[XW-1:BW];
  assign pair_col  = word[CW-1:1];
  assign odd_addr  = {rd_row, pair_col};
  assign even_addr = {rd_row, pair_col + (CW-1)'(word[0])};
  assign wr_addr   = {wr_row, wr_word[CW-1:1]};

  for (genvar g = 0; g < 4; g++) begin : g_bank
    localparam int PAIR = g / 2;
    localparam int HALF = g % 2;
    logic [HALF_W-1:0] ram [DEPTH];
    logic [HALF_W-1:0] q;
    logic [AW-1:0]     ra;
    assign ra = (PAIR == 1) ? odd_addr : even_addr;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_word[0] == 1'(PAIR)))
        ram[wr_addr] <= wr_data[HALF*HALF_W +: HALF_W];
      if (rd_en)
        q <= ram[ra];
    end
    assign bank_q[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      first_odd_q <= 1'b0;
      ofs_q       <= '0;
      win_base    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        first_odd_q <= word[0];
        ofs_q       <= phys_x[BW-1:0];
      end
      if (adv_en)
        win_base <= win_base + XW'(STEP_PIX);
    end
  end

  assign joined  = first_odd_q ? {bank_q[1], bank_q[0], bank_q[3], bank_q[2]}
                               : {bank_q[3], bank_q[2], bank_q[1], bank_q[0]};
  assign rd_data = WORD_W'(joined >> (ofs_q * PIX_BITS));
endmodule

module ref_window_mem_chk #(
  parameter int XW = 7,
  parameter int STEP_PIX = 16,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_en,
  input logic [XW-1:0]     win_base,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data
);
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R8
  AST_IDLE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!rd_en && rd_valid) |=> $stable(rd_data)); // R8
  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n) adv_en |=> win_base == XW'($past(win_base) + XW'(STEP_PIX))); // R5
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !adv_en |=> $stable(win_base)); // R5
  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |-> (!rd_valid && win_base == '0)); // R9
endmodule

bind ref_window_mem ref_window_mem_chk #(.XW(XW), .STEP_PIX(STEP_PIX), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .win_base(win_base),
  .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/ref_window_mem_tb.sv
module ref_window_mem_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_en = 1'b0;
  logic [6:0]  win_base;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_row = '0;
  logic [3:0]  wr_word = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_row = '0;
  logic [6:0]  rd_x = '0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int checks = 0;
  int fails = 0;
  int tb_base = 0;
  bit ov5 = 0, ov6 = 0;

  ref_window_mem dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pix(int y, int x);
    logic [7:0] v;
    v = 8'(y * 7 + x * 13 + 5);
    if ((ov5 && y == 5 && x / 8 == 3) || (ov6 && y == 6 && x / 8 == 2)) v = ~v;
    return v;
  endfunction

  function automatic logic [63:0] word_of(int y, int w);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = pix(y, w * 8 + k);
    return d;
  endfunction

  function automatic logic [63:0] run_of(int y, int rx);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = pix(y, (tb_base + rx + k) % 128);
    return d;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, int y, int rx);
    logic [63:0] e;
    e = run_of(y, rx);
    @(negedge clk);
    rd_en = 1'b1; rd_row = 7'(y); rd_x = 7'(rx);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {63'd0, rd_valid}, 64'd1);
    chk(req, rd_data, e);
  endtask

  task automatic write_word(int y, int w, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 7'(y); wr_word = 4'(w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 valid", {63'd0, rd_valid}, 64'd0);
    chk("R9 base", {57'd0, win_base}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid after release", {63'd0, rd_valid}, 64'd0);
    chk("R9 base after release", {57'd0, win_base}, 64'd0);
  endtask

  task automatic t_fill;
    for (int y = 0; y < 128; y++)
      for (int w = 0; w < 16; w++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = 7'(y); wr_word = 4'(w); wr_data = word_of(y, w);
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_aligned;
    read_chk("R1 aligned x=24", 10, 24);
    read_chk("R1 aligned x=0", 0, 0);
    read_chk("R1 aligned last row", 127, 64);
  endtask

  task automatic t_unaligned;
    read_chk("R2 even start ofs3", 20, 3);
    read_chk("R2 even start ofs7", 33, 39);
    read_chk("R3 odd start ofs5", 20, 13);
    read_chk("R3 odd aligned", 41, 8);
    read_chk("R3 odd start ofs1", 77, 57);
  endtask

  task automatic t_wrap;
    read_chk("R4 word15 ofs5", 50, 125);
    read_chk("R4 word15 aligned", 50, 120);
    read_chk("R4 word14 ofs6", 99, 118);
  endtask

  task automatic t_idle;
    logic [63:0] held;
    read_chk("R8 setup", 3, 19);
    held = rd_data;
    @(negedge clk);
    chk("R8 valid low", {63'd0, rd_valid}, 64'd0);
    chk("R8 data held", rd_data, held);
  endtask

  task automatic t_base;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); adv_en = 1'b1;
    end
    @(negedge clk); adv_en = 1'b0;
    tb_base = 48;
    chk("R5 base 48", {57'd0, win_base}, 64'd48);
    read_chk("R5 offset read", 12, 0);
    read_chk("R5 modulo read", 12, 90);
    read_chk("R5 offset unaligned", 12, 75);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); adv_en = 1'b1;
    end
    @(negedge clk); adv_en = 1'b0;
    tb_base = 0;
    chk("R5 base wraps to 0", {57'd0, win_base}, 64'd0);
    read_chk("R5 after wrap", 12, 5);
  endtask

  task automatic t_concurrent;
    logic [63:0] e;
    e = run_of(5, 0);
    @(negedge clk);
    rd_en = 1'b1; rd_row = 7'd5; rd_x = 7'd0;
    wr_en = 1'b1; wr_row = 7'd5; wr_word = 4'd3; wr_data = ~word_of(5, 3);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    ov5 = 1;
    chk("R6 read beside write", rd_data, e);
    read_chk("R6 new data visible", 5, 24);
    read_chk("R6 new data unaligned", 5, 20);
  endtask

  task automatic t_rdw;
    logic [63:0] e;
    e = run_of(6, 16);
    @(negedge clk);
    rd_en = 1'b1; rd_row = 7'd6; rd_x = 7'd16;
    wr_en = 1'b1; wr_row = 7'd6; wr_word = 4'd2; wr_data = ~word_of(6, 2);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    ov6 = 1;
    chk("R7 old data on collision", rd_data, e);
    read_chk("R7 new data next read", 6, 16);
    write_word(6, 2, word_of(6, 2));
  endtask

  initial begin
    t_reset;
    t_fill;
    t_aligned;
    t_unaligned;
    t_wrap;
    t_idle;
    t_base;
    t_concurrent;
    t_rdw;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule